// File: doc/BRIEF.md
# Radix-4 Carry-Save Divider Recurrence

The block runs the iterative core of a fractional divider based on radix-4 digit recurrence. It receives a normalized dividend and a normalized divisor, each a fraction in [1/2, 1) with its leading one in the top bit. It then produces one signed quotient digit per cycle, taken from {-2, -1, 0, 1, 2}. The partial residual is held in carry-save form and is never assimilated inside the loop. The dividend enters the recurrence scaled by 1/4, so the residual uses 55 fractional bits and a sign bit.

Digit selection is retimed. The digit for the next iteration is chosen from the carry-save adder outputs at the end of the current cycle and is held in a three-bit register. The operand multiplexer sits outside the loop. On a start, the digit register is preset to 1 and the multiplexer feeds the dividend, so the first cycle writes w[0] = x into the residual. Every later cycle feeds the divisor. An operation takes one load cycle, 28 digit cycles and one remainder cycle. In the remainder cycle a sign/zero detector adds the two residual words. Outside that cycle the inputs of the detector are forced to zero. The quotient conversion and rounding stage downstream consumes the digit stream and the remainder flags.

Top module: `radix4_div_core`

## Requirements
- R1: After reset, ready_o is 1, and digit_valid_o, last_o, rem_valid_o, rem_neg_o and rem_zero_o are all 0.
- R2: start_i is sampled only in cycles where ready_o is 1. A start raised while the block is busy does not change the running operation and does not cause an extra result.
- R3: Once a start is accepted, ready_o stays 0 for exactly 30 cycles (1 load, 28 digit, 1 remainder) and then returns to 1.
- R4: digit_valid_o is 1 for exactly 28 consecutive cycles. The first of these is the second cycle after the accepting clock edge. digit_o is 3-bit two's complement and always lies in -2..2 while valid.
- R5: last_o is 1 only together with the 28th digit of an operation.
- R6: With Q = sum of q_i·4^(28-i) over the 28 digits, the final residual w = x·4^27 − Q·d satisfies |w| ≤ (2/3)·d.
- R7: rem_valid_o is 1 for exactly one cycle, the cycle right after last_o.
- R8: While rem_valid_o is 1, rem_neg_o is 1 exactly when the final residual w of R6 is negative.
- R9: While rem_valid_o is 1, rem_zero_o is 1 exactly when w is zero. It is never 1 together with rem_neg_o.
- R10: rem_neg_o and rem_zero_o are 0 in every cycle where rem_valid_o is 0.
- R11: A start raised in the first cycle that ready_o is back at 1 is accepted immediately, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; taken when ready_o is 1 |
| dividend_i | input | MANT_W | Normalized dividend fraction, top bit 1 |
| divisor_i | input | MANT_W | Normalized divisor fraction, top bit 1 |
| ready_o | output | 1 | Idle and able to accept a start |
| digit_valid_o | output | 1 | digit_o holds a quotient digit |
| digit_o | output | 3 | Signed quotient digit, two's complement |
| last_o | output | 1 | Marks the final quotient digit |
| rem_valid_o | output | 1 | Remainder flags are valid |
| rem_neg_o | output | 1 | Final residual is negative |
| rem_zero_o | output | 1 | Final residual is zero |

## Verification
The properties assume that both operands have their top bit set. The selection table is only valid for a normalized divisor, and the digit-range property depends on that. They also assume that start_i may be raised at any time, including while the block is busy. The stimulus forces the top bit of every operand, including pseudo-random ones, to 1. It raises start_i for several cycles in the middle of one operation, and it raises start_i again in the first ready cycle after another. Quotient correctness is judged from the remainder bound and the flag values reconstructed from the digit stream, not from one fixed digit sequence, because a redundant digit set allows several valid sequences.

// File: rtl/radix4_div_pkg.sv
package radix4_div_pkg;

  typedef logic signed [2:0] qdig_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_STEP,
    PH_REM
  } phase_e;

  localparam int EST_W = 7;

  // selection thresholds in units of 1/16
  typedef struct packed {
    logic signed [EST_W-1:0] up2;
    logic signed [EST_W-1:0] up1;
    logic signed [EST_W-1:0] up0;
    logic signed [EST_W-1:0] upm1;
  } sel_bounds_t;

  function automatic sel_bounds_t sel_bounds(input logic [2:0] idx);
    sel_bounds_t b;
    case (idx)
      3'd0:    b = '{7'sd12, 7'sd4, -7'sd4, -7'sd13};
      3'd1:    b = '{7'sd14, 7'sd4, -7'sd6, -7'sd15};
      3'd2:    b = '{7'sd15, 7'sd4, -7'sd6, -7'sd16};
      3'd3:    b = '{7'sd16, 7'sd4, -7'sd6, -7'sd18};
      3'd4:    b = '{7'sd18, 7'sd6, -7'sd8, -7'sd20};
      3'd5:    b = '{7'sd20, 7'sd6, -7'sd8, -7'sd20};
      3'd6:    b = '{7'sd20, 7'sd8, -7'sd8, -7'sd22};
      default: b = '{7'sd22, 7'sd8, -7'sd8, -7'sd24};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/radix4_div_ctrl.sv
module radix4_div_ctrl
  import radix4_div_pkg::*;
#(
  parameter int NUM_DIGITS = 28
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o,
  output logic load_o,
  output logic use_x_o,
  output logic step_o,
  output logic digit_valid_o,
  output logic last_o,
  output logic rem_en_o
);

  localparam int CNT_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_DIGITS - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, at_last;

  assign accept  = (phase_q == PH_IDLE) && start_i;
  assign at_last = (phase_q == PH_STEP) && (cnt_q == CNT_LAST);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_LOAD;
      PH_LOAD: begin
        phase_d = PH_STEP;
        cnt_d   = '0;
      end
      PH_STEP: begin
        if (at_last) phase_d = PH_REM;
        else         cnt_d   = cnt_q + 1'b1;
      end
      PH_REM:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready_o       = (phase_q == PH_IDLE);
  assign load_o        = accept;
  assign use_x_o       = (phase_q == PH_LOAD);
  assign step_o        = (phase_q == PH_LOAD) || (phase_q == PH_STEP);
  assign digit_valid_o = (phase_q == PH_STEP);
  assign last_o        = at_last;
  assign rem_en_o      = (phase_q == PH_REM);

endmodule

// File: rtl/radix4_div_sel.sv
module radix4_div_sel
  import radix4_div_pkg::*;
(
  input  logic [EST_W-1:0] sum_top_i,
  input  logic [EST_W-1:0] car_top_i,
  input  logic [2:0]       d_idx_i,
  output qdig_t            q_o
);

  logic signed [EST_W-1:0] est;
  sel_bounds_t             bnd;

  // short assimilation of the truncated estimate, wraps mod 2^7
  assign est = signed'(sum_top_i + car_top_i);
  assign bnd = sel_bounds(d_idx_i);

  always_comb begin
    if      (est >= bnd.up2)  q_o = 3'sd2;
    else if (est >= bnd.up1)  q_o = 3'sd1;
    else if (est >= bnd.up0)  q_o = 3'sd0;
    else if (est >= bnd.upm1) q_o = -3'sd1;
    else                      q_o = -3'sd2;
  end

endmodule

// File: rtl/radix4_div_recur.sv
module radix4_div_recur
  import radix4_div_pkg::*;
#(
  parameter int MANT_W = 53
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              use_x_i,
  input  logic [MANT_W-1:0] x_i,
  input  logic [MANT_W-1:0] d_i,
  output qdig_t             q_o,
  output logic [MANT_W+2:0] sum_o,
  output logic [MANT_W+2:0] car_o
);

  localparam int W_W = MANT_W + 3;  // sign + (MANT_W+2) fraction bits

  logic [MANT_W-1:0] x_q, d_q;
  logic [W_W-1:0]    sum_q, car_q;
  qdig_t             q_q, q_nxt;

  logic [W_W-1:0] x_ext, d_ext, opnd, mag, mult;
  logic [W_W-1:0] a_in, b_in, sum_n, car_n, maj;
  logic           two_x, do_sub, do_zero;
  logic [2:0]     d_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      x_q <= x_i;
      d_q <= d_i;
    end
  end

  // operand alignment: x enters as x/4, d aligned to the fraction grid
  assign x_ext = {3'b000, x_q};
  assign d_ext = {1'b0, d_q, 2'b00};

  // select changes once per operation, outside the digit loop
  assign opnd = use_x_i ? x_ext : d_ext;

  assign two_x   = !use_x_i && ((q_q == 3'sd2) || (q_q == -3'sd2));
  assign do_sub  = !use_x_i && !q_q[2] && (q_q != 3'sd0);
  assign do_zero = !use_x_i && (q_q == 3'sd0);

  assign mag  = two_x ? {opnd[W_W-2:0], 1'b0} : opnd;
  assign mult = do_zero ? '0 : (do_sub ? ~mag : mag);

  // 3:2 compression of 4*ws, 4*wc and the multiple
  assign a_in  = {sum_q[W_W-3:0], 2'b00};
  assign b_in  = {car_q[W_W-3:0], 2'b00};
  assign sum_n = a_in ^ b_in ^ mult;
  assign maj   = (a_in & b_in) | (a_in & mult) | (b_in & mult);
  assign car_n = {maj[W_W-2:0], do_sub};

  assign d_idx = d_q[MANT_W-2 -: 3];

  radix4_div_sel i_sel (
    .sum_top_i (sum_n[W_W-1 -: EST_W]),
    .car_top_i (car_n[W_W-1 -: EST_W]),
    .d_idx_i   (d_idx),
    .q_o       (q_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      car_q <= '0;
      q_q   <= 3'sd0;
    end else if (load_i) begin
      sum_q <= '0;
      car_q <= '0;
      q_q   <= 3'sd1;
    end else if (step_i) begin
      sum_q <= sum_n;
      car_q <= car_n;
      q_q   <= q_nxt;
    end
  end

  assign q_o   = q_q;
  assign sum_o = sum_q;
  assign car_o = car_q;

endmodule

// File: rtl/radix4_div_szd.sv
module radix4_div_szd #(
  parameter int W_W = 56
) (
  input  logic           en_i,
  input  logic [W_W-1:0] sum_i,
  input  logic [W_W-1:0] car_i,
  output logic           neg_o,
  output logic           zero_o
);

  logic [W_W-1:0] s_g, c_g, tot;

  // inputs parked at zero outside the remainder cycle
  assign s_g = en_i ? sum_i : '0;
  assign c_g = en_i ? car_i : '0;
  assign tot = s_g + c_g;

  assign neg_o  = en_i && tot[W_W-1];
  assign zero_o = en_i && (tot == '0);

endmodule

// File: rtl/radix4_div_core.sv
module radix4_div_core
  import radix4_div_pkg::*;
#(
  parameter int MANT_W     = 53,
  parameter int NUM_DIGITS = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MANT_W-1:0] dividend_i,
  input  logic [MANT_W-1:0] divisor_i,
  output logic              ready_o,
  output logic              digit_valid_o,
  output logic [2:0]        digit_o,
  output logic              last_o,
  output logic              rem_valid_o,
  output logic              rem_neg_o,
  output logic              rem_zero_o
);

  localparam int W_W = MANT_W + 3;

  logic           load, use_x, step, rem_en;
  qdig_t          q_cur;
  logic [W_W-1:0] res_sum, res_car;

  radix4_div_ctrl #(
    .NUM_DIGITS (NUM_DIGITS)
  ) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .ready_o       (ready_o),
    .load_o        (load),
    .use_x_o       (use_x),
    .step_o        (step),
    .digit_valid_o (digit_valid_o),
    .last_o        (last_o),
    .rem_en_o      (rem_en)
  );

  radix4_div_recur #(
    .MANT_W (MANT_W)
  ) i_recur (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .use_x_i (use_x),
    .x_i     (dividend_i),
    .d_i     (divisor_i),
    .q_o     (q_cur),
    .sum_o   (res_sum),
    .car_o   (res_car)
  );

  radix4_div_szd #(
    .W_W (W_W)
  ) i_szd (
    .en_i   (rem_en),
    .sum_i  (res_sum),
    .car_i  (res_car),
    .neg_o  (rem_neg_o),
    .zero_o (rem_zero_o)
  );

  assign digit_o     = q_cur;
  assign rem_valid_o = rem_en;

endmodule

// File: rtl/radix4_div_core_chk.sv
module radix4_div_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       ready_o,
  input logic       digit_valid_o,
  input logic [2:0] digit_o,
  input logic       last_o,
  input logic       rem_valid_o,
  input logic       rem_neg_o,
  input logic       rem_zero_o
);

  a_r4_digit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_valid_o |-> ($signed(digit_o) >= -3'sd2 && $signed(digit_o) <= 3'sd2));

  a_r4_digit_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_valid_o |-> !ready_o);

  a_r5_last_in_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> digit_valid_o);

  a_r7_rem_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (rem_valid_o && !digit_valid_o));

  a_r3_ready_after_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_valid_o |=> ready_o);

  a_r2_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !rem_valid_o) |=> !ready_o);

  a_r11_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);

  a_r10_flags_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rem_valid_o |-> (!rem_neg_o && !rem_zero_o));

  a_r9_zero_not_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_valid_o |-> !(rem_neg_o && rem_zero_o));

endmodule

bind radix4_div_core radix4_div_core_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .ready_o       (ready_o),
  .digit_valid_o (digit_valid_o),
  .digit_o       (digit_o),
  .last_o        (last_o),
  .rem_valid_o   (rem_valid_o),
  .rem_neg_o     (rem_neg_o),
  .rem_zero_o    (rem_zero_o)
);

// File: tb/test_radix4_div_core.sv
module test_radix4_div_core;

  localparam int MANT_W     = 53;
  localparam int NUM_DIGITS = 28;
  localparam int OP_CYCLES  = NUM_DIGITS + 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [MANT_W-1:0] dividend, divisor;
  logic              ready, digit_valid, last, rem_valid, rem_neg, rem_zero;
  logic [2:0]        digit;

  always #5 clk = ~clk;

  radix4_div_core #(
    .MANT_W     (MANT_W),
    .NUM_DIGITS (NUM_DIGITS)
  ) i_radix4_div_core (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .dividend_i    (dividend),
    .divisor_i     (divisor),
    .ready_o       (ready),
    .digit_valid_o (digit_valid),
    .digit_o       (digit),
    .last_o        (last),
    .rem_valid_o   (rem_valid),
    .rem_neg_o     (rem_neg),
    .rem_zero_o    (rem_zero)
  );

  typedef struct {
    logic [MANT_W-1:0] x;
    logic [MANT_W-1:0] d;
  } op_t;

  op_t         exp_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [63:0] rng   = 64'h9E37_79B9_7F4A_7C15;

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [MANT_W-1:0] rnd_norm();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return {1'b1, rng[MANT_W-2:0]};
  endfunction

  // scoreboard monitor: rebuilds Q from digits, checks remainder relation
  logic signed [127:0] q_acc = '0;
  int                  dig_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!rem_valid)
        chk(!rem_neg && !rem_zero,
            $sformatf("R10 flags outside rem cycle: neg=%0b zero=%0b expected 0 0", rem_neg, rem_zero));
      if (digit_valid) begin
        chk($signed(digit) >= -3'sd2 && $signed(digit) <= 3'sd2,
            $sformatf("R4 digit range: got %0d expected -2..2", $signed(digit)));
        q_acc = q_acc * 4 + {{125{digit[2]}}, digit};
        dig_cnt++;
      end
      if (rem_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected result: got extra remainder expected none");
        end else begin
          op_t                 op;
          logic signed [127:0] xw, dw, w, aw;
          op = exp_q.pop_front();
          xw = 128'(op.x);
          dw = 128'(op.d);
          w  = (xw <<< 56) - q_acc * 4 * dw;
          aw = (w < 0) ? -w : w;
          chk(dig_cnt == NUM_DIGITS,
              $sformatf("R4 digit count: got %0d expected %0d", dig_cnt, NUM_DIGITS));
          chk(aw * 3 <= dw * 8,
              $sformatf("R6 remainder bound: got |w|*3=%0d expected <= %0d", aw * 3, dw * 8));
          chk(rem_neg == (w < 0),
              $sformatf("R8 sign flag: got %0b expected %0b", rem_neg, (w < 0)));
          chk(rem_zero == (w == 0),
              $sformatf("R9 zero flag: got %0b expected %0b", rem_zero, (w == 0)));
        end
        q_acc   = '0;
        dig_cnt = 0;
      end
    end
  end

  // driver: pushes expected item, checks the per-cycle handshake timing
  task automatic run_op(input logic [MANT_W-1:0] x, input logic [MANT_W-1:0] d, input bit poke);
    int k;
    int bad_dv, bad_last, bad_rv;
    while (!ready) @(negedge clk);
    dividend = x;
    divisor  = d;
    start    = 1'b1;
    exp_q.push_back('{x: x, d: d});
    @(negedge clk);
    start    = 1'b0;
    dividend = ~x;
    divisor  = {1'b1, ~d[MANT_W-2:0]};
    chk(!ready, $sformatf("R11 start accepted: ready=%0b expected 0", ready));
    k = 1; bad_dv = 0; bad_last = 0; bad_rv = 0;
    while (!ready && k < OP_CYCLES + 5) begin
      if (digit_valid != (k >= 2 && k <= NUM_DIGITS + 1)) bad_dv++;
      if (last != (k == NUM_DIGITS + 1)) bad_last++;
      if (rem_valid != (k == NUM_DIGITS + 2)) bad_rv++;
      start = poke && (k >= 5) && (k < 10);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k - 1 == OP_CYCLES,
        $sformatf("R3 busy cycles: got %0d expected %0d", k - 1, OP_CYCLES));
    chk(bad_dv == 0, $sformatf("R4 digit window: got %0d wrong cycles expected 0", bad_dv));
    chk(bad_last == 0, $sformatf("R5 last marker: got %0d wrong cycles expected 0", bad_last));
    chk(bad_rv == 0, $sformatf("R7 remainder cycle: got %0d wrong cycles expected 0", bad_rv));
  endtask

  localparam logic [MANT_W-1:0] HALF  = {1'b1, {(MANT_W-1){1'b0}}};
  localparam logic [MANT_W-1:0] TQ    = {2'b11, {(MANT_W-2){1'b0}}};
  localparam logic [MANT_W-1:0] MAXV  = {MANT_W{1'b1}};

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    dividend = '0;
    divisor  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !digit_valid && !last && !rem_valid && !rem_neg && !rem_zero,
        $sformatf("R1 reset state: rdy=%0b dv=%0b last=%0b rv=%0b neg=%0b zero=%0b expected 1 0 0 0 0 0",
                  ready, digit_valid, last, rem_valid, rem_neg, rem_zero));

    run_op(HALF, HALF, 1'b0);   // exact, zero remainder
    run_op(TQ, HALF, 1'b0);     // exact, quotient 1.5
    run_op(MAXV, MAXV, 1'b0);
    run_op(HALF, MAXV, 1'b1);   // R2: start poked while busy
    run_op(MAXV, HALF, 1'b0);
    run_op(TQ, MAXV, 1'b0);
    for (int i = 0; i < 12; i++) begin
      logic [MANT_W-1:0] rx, rd;
      rx = rnd_norm();
      rd = rnd_norm();
      run_op(rx, rd, (i == 3));
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0,
        $sformatf("R2 pending results: got %0d expected 0", exp_q.size()));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R3: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule